// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device from power-up into normal operation. A start pulse launches a fixed script on the memory command/address interface. The script issues one precharge of all banks, then eight auto-refresh commands, then one load of the mode register. A programmable number of idle cycles separates each command from the next one. When the script is done, the block raises a sticky ready flag and enables a periodic refresh timer.

The refresh period has two programmable stages: a prescaler, and a refresh count that advances once per prescaler wrap. Each time the second stage wraps, the block emits a one-cycle refresh request for a downstream memory controller. Once the script is complete the block drives only no-operation commands, so the controller owns the command bus from then on.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset, and after reset until a start pulse arrives, cmd_o is NOP (code 0), addr_o and ba_o are zero, and init_done and refresh_req are low.
- R2: A start pulse sampled while idle makes the next cycle carry a precharge-all command (code 1), with address bit AP_BIT (default 10) set, all other address bits zero, and bank 0.
- R3: After the precharge, exactly eight auto-refresh commands (code 2) follow, each with address and bank zero.
- R4: After the eighth refresh, one mode-register load (code 3) follows, with addr_o equal to mode_val and ba_o equal to 0.
- R5: init_done rises tmrd_gap+1 cycles after the mode-register load and stays high until reset.
- R6: While init_done is high, cmd_o stays NOP.
- R7: refresh_req is a single-cycle pulse. The first pulse comes (prescale+1)*(refresh_cnt+1) cycles after init_done rises, and the pulses repeat at that same interval without any reload from outside.
- R8: Between two consecutive script commands the block drives exactly G NOP cycles. G is trp_gap after the precharge, trfc_gap after each refresh, and tmrd_gap after the mode load. G = 0 gives back-to-back commands.
- R9: A start pulse that arrives while the script runs, or after it has finished, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the script when idle |
| trp_gap | input | GAP_W | Idle cycles after the precharge |
| trfc_gap | input | GAP_W | Idle cycles after each refresh |
| tmrd_gap | input | GAP_W | Idle cycles after the mode load |
| mode_val | input | ROW_W | Value placed on the address lines by the mode load |
| prescale | input | PRE_W | Prescaler terminal count (period prescale+1) |
| refresh_cnt | input | RTC_W | Refresh timer terminal count in prescaler ticks |
| cmd_o | output | 2 | Command: 0 NOP, 1 precharge all, 2 auto-refresh, 3 mode load |
| addr_o | output | ROW_W | Address lines |
| ba_o | output | BANK_W | Bank address |
| init_done | output | 1 | Script finished, stays high until reset |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The bound checker watches every cycle for properties that hold at every instant: the stickiness of init_done, the silence of the command bus after it, refresh requests only in normal operation, the address and bank contents of the precharge and mode-load commands, and a NOP after each command when all gaps are nonzero. Properties that depend on absolute cycle positions can only be shown by the bench's scenarios: the exact count of eight refreshes, the exact gap lengths, the rise time of init_done, the refresh period, and the rejection of a late start pulse. The bench's reference model predicts every output on every cycle for several gap and timer settings, including zero gaps.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ROW_W   = 13,
  parameter int BANK_W  = 2,
  parameter int GAP_W   = 8,
  parameter int PRE_W   = 8,
  parameter int RTC_W   = 8,
  parameter int CBR_NUM = 8,
  parameter int AP_BIT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [GAP_W-1:0]  trp_gap,
  input  logic [GAP_W-1:0]  trfc_gap,
  input  logic [GAP_W-1:0]  tmrd_gap,
  input  logic [ROW_W-1:0]  mode_val,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RTC_W-1:0]  refresh_cnt,
  output logic [1:0]        cmd_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [BANK_W-1:0] ba_o,
  output logic              init_done,
  output logic              refresh_req
);
  localparam int CBR_W = (CBR_NUM > 1) ? $clog2(CBR_NUM) : 1;
  localparam logic [CBR_W-1:0] CBR_LAST = CBR_W'(CBR_NUM - 1);

  localparam logic [1:0] CMD_NOP = 2'd0;
  localparam logic [1:0] CMD_PRE = 2'd1;
  localparam logic [1:0] CMD_REF = 2'd2;
  localparam logic [1:0] CMD_MRS = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WPRE, S_WREF, S_WMRS, S_RUN} state_t;

  state_t            st;
  logic [GAP_W-1:0]  gap_q;
  logic [CBR_W-1:0]  ref_idx;
  logic [PRE_W-1:0]  pre_q;
  logic [RTC_W-1:0]  rt_q;
  logic [1:0]        cmd_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BANK_W-1:0] ba_q;
  logic              done_q;
  logic              req_q;

  wire gap_zero = (gap_q == '0);
  wire pre_wrap = (pre_q == prescale);
  wire rt_wrap  = (rt_q == refresh_cnt);

  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;
  assign ba_o        = ba_q;
  assign init_done   = done_q;
  assign refresh_req = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gap_q   <= '0;
      ref_idx <= '0;
      pre_q   <= '0;
      rt_q    <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ba_q    <= '0;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      req_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            cmd_q          <= CMD_PRE;
            addr_q[AP_BIT] <= 1'b1;
            gap_q          <= trp_gap;
            st             <= S_WPRE;
          end
        end
        S_WPRE: begin
          if (gap_zero) begin
            cmd_q   <= CMD_REF;
            gap_q   <= trfc_gap;
            ref_idx <= '0;
            st      <= S_WREF;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        S_WREF: begin
          if (gap_zero) begin
            if (ref_idx == CBR_LAST) begin
              cmd_q  <= CMD_MRS;
              addr_q <= mode_val;
              gap_q  <= tmrd_gap;
              st     <= S_WMRS;
            end else begin
              cmd_q   <= CMD_REF;
              gap_q   <= trfc_gap;
              ref_idx <= ref_idx + 1'b1;
            end
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        S_WMRS: begin
          if (gap_zero) begin
            done_q <= 1'b1;
            pre_q  <= '0;
            rt_q   <= '0;
            st     <= S_RUN;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        S_RUN: begin
          if (pre_wrap) begin
            pre_q <= '0;
            if (rt_wrap) begin
              rt_q  <= '0;
              req_q <= 1'b1;
            end else begin
              rt_q <= rt_q + 1'b1;
            end
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sdram_init_seq_chk #(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int GAP_W  = 8,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GAP_W-1:0]  trp_gap,
  input logic [GAP_W-1:0]  trfc_gap,
  input logic [GAP_W-1:0]  tmrd_gap,
  input logic [ROW_W-1:0]  mode_val,
  input logic [1:0]        cmd_o,
  input logic [ROW_W-1:0]  addr_o,
  input logic [BANK_W-1:0] ba_o,
  input logic              init_done,
  input logic              refresh_req
);
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r6_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cmd_o == 2'd0);

  a_r7_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> init_done);

  a_r2_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd1) |-> (addr_o[AP_BIT] && $countones(addr_o) == 1 && ba_o == '0));

  a_r3_refresh_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd2) |-> (addr_o == '0 && ba_o == '0));

  a_r4_mode_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'd3) |-> (addr_o == mode_val && ba_o == '0));

  a_r8_gap_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 2'd0 && trp_gap != '0 && trfc_gap != '0 && tmrd_gap != '0)
      |=> cmd_o == 2'd0);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .GAP_W(GAP_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trp_gap(trp_gap), .trfc_gap(trfc_gap),
  .tmrd_gap(tmrd_gap), .mode_val(mode_val), .cmd_o(cmd_o), .addr_o(addr_o),
  .ba_o(ba_o), .init_done(init_done), .refresh_req(refresh_req)
);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  trp_gap = '0, trfc_gap = '0, tmrd_gap = '0;
  logic [12:0] mode_val = '0;
  logic [7:0]  prescale = '0, refresh_cnt = '0;
  logic [1:0]  cmd_o;
  logic [12:0] addr_o;
  logic [1:0]  ba_o;
  logic        init_done, refresh_req;

  int checks = 0;
  int errors = 0;
  int t = 0;
  int late_win = 0;
  bit chk_en = 1'b0;

  always #4 clk = ~clk;

  sdram_init_seq i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .trp_gap(trp_gap),
    .trfc_gap(trfc_gap), .tmrd_gap(tmrd_gap), .mode_val(mode_val),
    .prescale(prescale), .refresh_cnt(refresh_cnt), .cmd_o(cmd_o),
    .addr_o(addr_o), .ba_o(ba_o), .init_done(init_done),
    .refresh_req(refresh_req)
  );

  // cycle index since the start edge; 0 means idle
  always @(posedge clk) begin
    if (!rst_n) t = 0;
    else if (t > 0) t = t + 1;
    else if (start) t = 1;
  end

  always @(posedge clk) begin
    #2;
    if (chk_en) compare();
    if (late_win > 0) late_win = late_win - 1;
  end

  task automatic compare();
    int tr0, tm, te, per;
    logic [1:0]  e_cmd;
    logic [12:0] e_addr;
    logic        e_done, e_req;
    string tag;
    tr0 = int'(trp_gap) + 2;
    tm  = tr0 + 8 * (int'(trfc_gap) + 1);
    te  = tm + int'(tmrd_gap) + 1;
    per = (int'(prescale) + 1) * (int'(refresh_cnt) + 1);
    e_cmd = 2'd0; e_addr = '0; tag = "R8";
    if (t == 0) tag = "R1";
    else if (t == 1) begin e_cmd = 2'd1; e_addr = 13'h0400; tag = "R2"; end
    else if (t >= tr0 && t < tm && ((t - tr0) % (int'(trfc_gap) + 1)) == 0) begin
      e_cmd = 2'd2; tag = "R3";
    end else if (t == tm) begin e_cmd = 2'd3; e_addr = mode_val; tag = "R4"; end
    e_done = (t > 0) && (t >= te);
    e_req  = (t > te) && (((t - te) % per) == 0);
    if (t >= te && t > 0) tag = e_req ? "R7" : "R6";
    if (t == te) tag = "R5";
    if (late_win > 0) tag = "R9";
    checks++;
    if (cmd_o !== e_cmd || addr_o !== e_addr || ba_o !== 2'd0 ||
        init_done !== e_done || refresh_req !== e_req) begin
      errors++;
      $display("FAIL %s t=%0d actual cmd=%0d addr=%h ba=%0d done=%b req=%b expected cmd=%0d addr=%h ba=0 done=%b req=%b",
               tag, t, cmd_o, addr_o, ba_o, init_done, refresh_req,
               e_cmd, e_addr, e_done, e_req);
    end
  endtask

  task automatic run_case(input int rp, input int rfc, input int mrd,
                          input logic [12:0] mv, input int p, input int r,
                          input int ncyc, input int late1, input int late2,
                          input int idle_pre);
    @(negedge clk);
    rst_n = 1'b0;
    trp_gap = 8'(rp); trfc_gap = 8'(rfc); tmrd_gap = 8'(mrd);
    mode_val = mv; prescale = 8'(p); refresh_cnt = 8'(r);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle cycles with no start
    repeat (idle_pre) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < ncyc; i++) begin
      if (i == late1 || i == late2) begin
        start = 1'b1; late_win = 4;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    chk_en = 1'b1;
    // mid-script start and post-done start are ignored (R9)
    run_case(2, 3, 1, 13'h0232, 3, 2, 110, 10, 60, 3);
    // zero gaps: back-to-back commands (R8), short refresh period (R7)
    run_case(0, 0, 0, 13'h1fff, 0, 1, 40, 5, 0, 1);
    // period of one cycle
    run_case(1, 0, 2, 13'h0055, 0, 0, 30, 0, 0, 2);
    // longer gaps, prescaler-only period
    run_case(7, 5, 4, 13'h0a31, 2, 0, 100, 20, 0, 0);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule